// File: doc/BRIEF.md
# Sequential Signed Restoring Divider

This block divides a two's complement dividend of twice the operand width by a two's complement divisor of the operand width. It produces a quotient and a remainder of the operand width, working one shift-and-correct iteration per clock. The caller drives the operands together with a one-cycle start pulse while the block is idle. `busy_o` stays high while the iterations run. A one-cycle `done_o` pulse then marks valid results, which hold until the next completion.

The divisor sits in a register M. The dividend sits in a double-width register pair A:Q, whose upper half A later holds the remainder. Each step shifts A:Q left by one bit. The step then subtracts M from A when both have the same sign, and adds M to A otherwise. A step whose correction flips the sign of A with a non-zero result is undone. The quotient sign is fixed only at the end. A zero divisor never enters the loop: the block raises a flag together with `done_o` instead.

Top module: `sdiv_restore`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o` and `dz_o` are low, and `quotient_o` and `remainder_o` are zero.
- R2: A start sampled while idle with a non-zero divisor raises `busy_o` for exactly W clock cycles, where W is the operand width. In the cycle after the last of these, `done_o` is high for one cycle and `busy_o` is low.
- R3: Each iteration shifts A:Q left by one bit. A takes the dividend's upper W bits at load. After the shift, A becomes A−M if bit W−1 of A equals bit W−1 of M, and A+M otherwise.
- R4: After the correction, Q bit 0 becomes 1 in either of two cases: A's bit W−1 equals its value just after the shift, or A is zero. In all other cases, Q bit 0 becomes 0 and A returns to its value just after the shift.
- R5: At `done_o`, `remainder_o` equals A after the W-th iteration. Positive operands give the ordinary quotient and remainder, for example 100/7 gives 14 remainder 2.
- R6: At `done_o`, `quotient_o` equals Q when dividend bit 2W−1 equals divisor bit W−1, and equals the two's complement of Q otherwise.
- R7: A start with a zero divisor runs no iteration. `done_o` and `dz_o` are high in the next cycle, `busy_o` stays low, and `quotient_o` and `remainder_o` keep their previous values.
- R8: A start raised while `busy_o` is high is ignored. The running division finishes on its original schedule with results from its original operands.
- R9: `dz_o` is low whenever a division with a non-zero divisor completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| dividend_i | input | 2W | Sign-extended two's complement dividend |
| divisor_i | input | W | Two's complement divisor |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dz_o | output | 1 | Divisor was zero, valid with done_o |
| quotient_o | output | W | Signed quotient |
| remainder_o | output | W | Remainder |

## Verification
Every cycle, the assertions check four things. `busy_o` rises only after an accepted start. The fall of `busy_o` always brings `done_o`. A zero-divisor flag never appears without `done_o` or with `busy_o`. M never changes during a run, so starts raised mid-run cannot disturb it. The assertions cannot show the arithmetic: the per-step add/subtract and restore rule, the final sign correction and the held results after a zero divisor. Only the bench's scoreboard can, comparing results for mixed-sign operand sets against values worked out from the step rules. The exact run length and the ignored mid-run start are also confirmed by the bench's cycle counts.

// File: rtl/sdiv_pkg.sv
// Package sdiv_pkg: shared constants for the signed restoring divider.
// Assumes: users size their operands from OPW_DEF when not overridden.
package sdiv_pkg;
    localparam int OPW_DEF = 8;

    // Operation the step logic applied to A in one iteration.
    typedef enum logic {
        OP_SUB = 1'b0,
        OP_ADD = 1'b1
    } step_op_e;
endpackage

// File: rtl/sdiv_step.sv
// Module sdiv_step: combinational single iteration of signed restoring division.
// Shifts A:Q left. Subtracts M from A (same signs) or adds it (different
// signs). Keeps the result when A's sign is unchanged or A is zero, and
// restores A otherwise.
// Assumes: operands are two's complement, W >= 2.
module sdiv_step
    import sdiv_pkg::*;
#(
    parameter int W = OPW_DEF
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] q_i,
    input  logic [W-1:0] m_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] q_o
);
    logic [W-1:0] a_sh;
    logic [W-1:0] q_sh;
    logic [W-1:0] a_try;
    logic         keep;
    step_op_e     op;

    // Shift A:Q left by one; the vacated Q bit is filled in below.
    always_comb begin
        {a_sh, q_sh} = {a_i, q_i} << 1;
    end

    // Pick add or subtract from the sign bits of M and the shifted A.
    always_comb begin
        op    = (a_sh[W-1] == m_i[W-1]) ? OP_SUB : OP_ADD;
        a_try = (op == OP_SUB) ? (a_sh - m_i) : (a_sh + m_i);
    end

    // Keep the trial result or restore, and set the new quotient bit.
    always_comb begin
        keep = (a_try[W-1] == a_sh[W-1]) || (a_try == '0);
        a_o  = keep ? a_try : a_sh;
        q_o  = {q_sh[W-1:1], keep};
    end
endmodule

// File: rtl/sdiv_ctrl.sv
// Module sdiv_ctrl: sequencing for the divider.
// Accepts a start only while idle. A zero divisor is reported at once with
// no run. Otherwise it runs exactly W iterations and flags the last one.
// Assumes: start_i and zero_i are valid in the same cycle.
module sdiv_ctrl #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic zero_i,
    output logic busy_o,
    output logic load_o,
    output logic zhit_o,
    output logic last_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          run_q;
    logic [CW-1:0] cnt_q;

    // Decode accepted starts and the final iteration.
    always_comb begin
        load_o = !run_q && start_i && !zero_i;
        zhit_o = !run_q && start_i && zero_i;
        last_o = run_q && (cnt_q == LAST);
        busy_o = run_q;
    end

    // Run flag and iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load_o) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) run_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the counter never passes the last iteration while running.
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= LAST));

    // R2: a run only starts after a load.
    p_run_from_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(load_o));
endmodule

// File: rtl/sdiv_restore.sv
// Module sdiv_restore: top of the sequential signed restoring divider.
// Holds M, A:Q and the sign-correction flag. Steps one iteration per clock
// and registers the quotient and remainder at completion.
// Assumes: dividend is already sign-extended to 2W bits.
module sdiv_restore
    import sdiv_pkg::*;
#(
    parameter int W = OPW_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2*W-1:0] dividend_i,
    input  logic [W-1:0]   divisor_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           dz_o,
    output logic [W-1:0]   quotient_o,
    output logic [W-1:0]   remainder_o
);
    logic [W-1:0] a_q, q_q, m_q;
    logic [W-1:0] a_nx, q_nx;
    logic [W-1:0] quo_q, rem_q;
    logic         neg_q, done_q, dz_q;
    logic         busy, load, zhit, last;
    logic         zero_div;

    // Divisor-zero detection for the start decode.
    always_comb begin
        zero_div = (divisor_i == '0);
    end

    sdiv_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .zero_i  (zero_div),
        .busy_o  (busy),
        .load_o  (load),
        .zhit_o  (zhit),
        .last_o  (last)
    );

    sdiv_step #(.W(W)) u_step (
        .a_i (a_q),
        .q_i (q_q),
        .m_i (m_q),
        .a_o (a_nx),
        .q_o (q_nx)
    );

    // Operand load and per-cycle iteration of A:Q.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            q_q   <= '0;
            m_q   <= '0;
            neg_q <= 1'b0;
        end else if (load) begin
            a_q   <= dividend_i[2*W-1:W];
            q_q   <= dividend_i[W-1:0];
            m_q   <= divisor_i;
            neg_q <= dividend_i[2*W-1] ^ divisor_i[W-1];
        end else if (busy) begin
            a_q <= a_nx;
            q_q <= q_nx;
        end
    end

    // Completion pulse, zero flag and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            dz_q   <= 1'b0;
            quo_q  <= '0;
            rem_q  <= '0;
        end else begin
            done_q <= zhit || last;
            dz_q   <= zhit;
            if (last) begin
                rem_q <= a_nx;
                quo_q <= neg_q ? (~q_nx + 1'b1) : q_nx;
            end
        end
    end

    // Drive outputs from registers.
    always_comb begin
        busy_o      = busy;
        done_o      = done_q;
        dz_o        = dz_q;
        quotient_o  = quo_q;
        remainder_o = rem_q;
    end

    // R2: busy rises only after a start request.
    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R2: the end of a run is always marked by done.
    p_fell_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o && !busy_o));

    // R7: zero flag only with done and never during a run.
    p_dz_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dz_o |-> (done_o && !busy_o));

    // R8: the divisor register is untouched by starts during a run.
    p_m_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(m_q));
endmodule

// File: tb/sim_sdiv_restore.sv
module sim_sdiv_restore;
    localparam int W = 8;

    typedef struct packed {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         dz;
        logic [7:0]   req;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [2*W-1:0] dividend_i = '0;
    logic [W-1:0]   divisor_i = '0;
    logic           busy_o, done_o, dz_o;
    logic [W-1:0]   quotient_o, remainder_o;

    int n_chk = 0;
    int n_bad = 0;
    exp_t sb[$];
    logic [W-1:0] last_q = '0;
    logic [W-1:0] last_r = '0;

    always #2 clk = ~clk;

    sdiv_restore #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o), .dz_o(dz_o),
        .quotient_o(quotient_o), .remainder_o(remainder_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Step rules of R3/R4 with the sign fix of R6.
    function automatic exp_t model(logic [2*W-1:0] d, logic [W-1:0] m);
        logic [W-1:0] a, q, ap;
        exp_t e;
        a = d[2*W-1:W];
        q = d[W-1:0];
        for (int i = 0; i < W; i++) begin
            {a, q} = {a, q} << 1;
            ap = a;
            if (a[W-1] == m[W-1]) a = a - m;
            else a = a + m;
            if ((a[W-1] == ap[W-1]) || (a == '0)) q[0] = 1'b1;
            else begin
                q[0] = 1'b0;
                a = ap;
            end
        end
        e.q = (d[2*W-1] != m[W-1]) ? (~q + 1'b1) : q;
        e.r = a;
        e.dz = 1'b0;
        e.req = 8'd3;
        return e;
    endfunction

    // Monitor: compare each completion with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quotient_o == e.q, e.dz ? "R7 quotient held" : "R6 quotient",
                      int'(quotient_o), int'(e.q));
                check(remainder_o == e.r, e.dz ? "R7 remainder held" : "R5 remainder",
                      int'(remainder_o), int'(e.r));
                check(dz_o == e.dz, e.dz ? "R7 dz flag" : "R9 dz low",
                      int'(dz_o), int'(e.dz));
                last_q = e.q;
                last_r = e.r;
            end
        end
    end

    // Driver: one division; optionally a stray start mid-run (R8).
    task automatic run_div(input logic [2*W-1:0] d, input logic [W-1:0] m,
                           input bit use_lit, input logic [W-1:0] lq,
                           input logic [W-1:0] lr, input bit stray);
        exp_t e;
        int cyc;
        if (m == '0) begin
            e.q = last_q; e.r = last_r; e.dz = 1'b1; e.req = 8'd7;
        end else if (use_lit) begin
            e.q = lq; e.r = lr; e.dz = 1'b0; e.req = 8'd5;
        end else begin
            e = model(d, m);
        end
        sb.push_back(e);
        dividend_i = d;
        divisor_i  = m;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (m == '0) begin
            check(done_o && dz_o && !busy_o, "R7 done+dz next cycle, no busy",
                  int'({done_o, dz_o, busy_o}), 6);
        end else begin
            cyc = 0;
            while (busy_o && cyc < 4 * W) begin
                cyc++;
                if (stray && cyc == 3) begin
                    dividend_i = 16'd77;
                    divisor_i  = 8'd3;
                    start_i    = 1'b1;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
            start_i = 1'b0;
            check(cyc == W, stray ? "R8 busy length with stray start" : "R2 busy length",
                  cyc, W);
            check(done_o && !busy_o, "R2 done after busy", int'({done_o, busy_o}), 2);
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy_o && !done_o && !dz_o, "R1 flags after reset",
              int'({busy_o, done_o, dz_o}), 0);
        check(quotient_o == '0 && remainder_o == '0, "R1 results after reset",
              int'({quotient_o, remainder_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: positive operands, hand-worked values
        run_div(16'd100, 8'd7,  1'b1, 8'd14, 8'd2,  1'b0);
        run_div(16'd143, 8'd11, 1'b1, 8'd13, 8'd0,  1'b0);
        run_div(16'd255, 8'd16, 1'b1, 8'd15, 8'd15, 1'b0);
        run_div(16'd0,   8'd5,  1'b1, 8'd0,  8'd0,  1'b0);
        // R3 R4 R6: mixed signs against the step rules
        run_div(-16'sd6,   8'd3,     1'b0, '0, '0, 1'b0);
        run_div(-16'sd100, 8'd7,     1'b0, '0, '0, 1'b0);
        run_div(16'd100,   -8'sd7,   1'b0, '0, '0, 1'b0);
        run_div(-16'sd100, -8'sd7,   1'b0, '0, '0, 1'b0);
        run_div(-16'sd127, 8'd10,    1'b0, '0, '0, 1'b0);
        // R7: zero divisor keeps previous results
        run_div(16'd50, 8'd0, 1'b0, '0, '0, 1'b0);
        // R8: stray start during a run is ignored
        run_div(16'd200, 8'd9, 1'b1, 8'd22, 8'd2, 1'b1);
        // R7 again right after a normal run
        run_div(-16'sd9, 8'd0, 1'b0, '0, '0, 1'b0);
        run_div(16'd127, -8'sd1, 1'b0, '0, '0, 1'b0);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2 all results seen", sb.size(), 0);
        finish_run();
    end
endmodule